// File: doc/BRIEF.md
# Converter Host Bus Controller

This block sits between a host bus and the successive-approximation engine of a 12-bit converter. It samples five asynchronous control levels (a chip enable, an active-low chip select, a read/convert level, a byte address and a word/byte mode level). From them it derives two actions. One is a one-cycle start request to the engine, together with a short-conversion flag. The other is a read of the last completed result onto a 12-line data bus, with an output-enable flag that stands in for three-state pins.

A read can present the whole result as one word, or split it for an 8-bit bus attached to the upper eight lines. In that case it gives either the upper eight result bits or the lower four result bits followed by four zeros. When the byte address is sampled at a start, it selects the conversion length. Stand-alone operation needs no extra pin. With enable and mode tied high and select and byte address tied low, a falling read/convert level starts a conversion and floats the bus, and a high level drives the result.

Top module: `adc_bus_ctrl`

## Requirements
- R1: With chip_en low or chip_sel_n high, no start pulse is issued and data_oe stays 0. Whenever data_oe is 0, data_out is all zeros.
- R2: When selected, rd_conv low requests a conversion and rd_conv high requests a read, which sets data_oe to 1. A start pulse and data_oe are never high together.
- R3: The byte_addr level seen at a start edge is output on len_short (0 = 12-bit conversion, 1 = 8-bit conversion).
- R4: During a read with word_mode = 1, data_out[11:0] equals the stored 12-bit result.
- R5: During a read with word_mode = 0 and byte_addr = 0, data_out[11:4] carries result bits 11..4 and data_out[3:0] is 0.
- R6: During a read with word_mode = 0 and byte_addr = 1, data_out[11:8] carries result bits 3..0, and data_out[7:0] is 0.
- R7: A change of byte_addr during an active read changes the driven byte with no new read cycle.
- R8: While busy, a start edge issues no start pulse and leaves busy set, but it does re-capture byte_addr onto len_short.
- R9: conv_start is a single-cycle pulse in the first cycle the selected-convert condition holds. Holding that condition issues no further pulse.
- R10: eng_done stores eng_result as the readable result and clears busy. A start edge in the same cycle as eng_done is accepted, and busy stays set.
- R11: In stand-alone wiring, a falling rd_conv starts a conversion and drops data_oe, and rd_conv high drives the result.
- R12: Every control input reaches the outputs three clock edges after it changes (two synchronizer stages and one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip enable, active high, asynchronous |
| chip_sel_n | input | 1 | Chip select, active low, asynchronous |
| rd_conv | input | 1 | 1 = read, 0 = convert, asynchronous |
| byte_addr | input | 1 | Byte select on reads, length select on starts |
| word_mode | input | 1 | 1 = 12-bit word reads, 0 = two-byte reads |
| eng_done | input | 1 | Engine finished, result valid this cycle |
| eng_result | input | 12 | Completed result from engine |
| conv_start | output | 1 | One-cycle start request to the engine |
| len_short | output | 1 | 1 = 8-bit conversion length |
| busy | output | 1 | Conversion in progress |
| data_out | output | 12 | Read data bus |
| data_oe | output | 1 | Bus drive enable |

## Verification
The two functions that can meet in one cycle are the end of a running conversion and the acceptance of a new start edge. The bench times a convert request so that its synchronized edge is evaluated in the same cycle that eng_done is high. It then expects one new start pulse and busy still set. A second case repeats the edge without eng_done and expects the edge to be ignored, with only the length flag updated.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
    localparam int unsigned RES_W_DEF   = 12;
    localparam int unsigned BYTE_W_DEF  = 8;
    localparam int unsigned SYNC_N_DEF  = 2;
    localparam int unsigned CTRL_IN_W   = 5;

    typedef struct packed {
        logic conv_prev;
        logic start;
        logic len_short;
        logic busy;
        logic oe;
    } ctrl_flags_t;
endpackage

// File: rtl/adc_bus_sync.sv
module adc_bus_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/adc_bus_rdmux.sv
module adc_bus_rdmux #(
    parameter int unsigned RES_W  = 12,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic             word_mode,
    input  logic             byte_addr,
    output logic [RES_W-1:0] bus_data
);
    localparam int unsigned LOW_W  = RES_W - BYTE_W;
    localparam int unsigned PAD_W  = BYTE_W - LOW_W;
    localparam int unsigned FREE_W = RES_W - BYTE_W;

    logic [BYTE_W-1:0] byte_hi;
    logic [BYTE_W-1:0] byte_lo;

    assign byte_hi = result[RES_W-1 -: BYTE_W];
    assign byte_lo = {result[LOW_W-1:0], {PAD_W{1'b0}}};

    always_comb begin
        if (word_mode)      bus_data = result;
        else if (byte_addr) bus_data = {byte_lo, {FREE_W{1'b0}}};
        else                bus_data = {byte_hi, {FREE_W{1'b0}}};
    end
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
    parameter int unsigned RES_W  = adc_bus_pkg::RES_W_DEF,
    parameter int unsigned BYTE_W = adc_bus_pkg::BYTE_W_DEF,
    parameter int unsigned SYNC_N = adc_bus_pkg::SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             chip_sel_n,
    input  logic             rd_conv,
    input  logic             byte_addr,
    input  logic             word_mode,
    input  logic             eng_done,
    input  logic [RES_W-1:0] eng_result,
    output logic             conv_start,
    output logic             len_short,
    output logic             busy,
    output logic [RES_W-1:0] data_out,
    output logic             data_oe
);
    import adc_bus_pkg::*;

    typedef struct packed {
        ctrl_flags_t      f;
        logic [RES_W-1:0] result;
        logic [RES_W-1:0] dout;
    } state_t;

    state_t st_d, st_q;

    logic [CTRL_IN_W-1:0] raw_in, sync_in;
    logic en_s, csn_s, rc_s, ba_s, wm_s;
    logic selected, want_conv, want_read, start_edge, accept;
    logic [RES_W-1:0] mux_data;

    assign raw_in = {chip_en, chip_sel_n, rd_conv, byte_addr, word_mode};

    adc_bus_sync #(.W(CTRL_IN_W), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_in)
    );

    assign {en_s, csn_s, rc_s, ba_s, wm_s} = sync_in;

    adc_bus_rdmux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_rdmux (
        .result    (st_q.result),
        .word_mode (wm_s),
        .byte_addr (ba_s),
        .bus_data  (mux_data)
    );

    always_comb begin
        selected   = en_s & ~csn_s;
        want_conv  = selected & ~rc_s;
        want_read  = selected & rc_s;
        start_edge = want_conv & ~st_q.f.conv_prev;
        accept     = start_edge & (~st_q.f.busy | eng_done);

        st_d             = st_q;
        st_d.f.conv_prev = want_conv;
        st_d.f.start     = accept;
        if (start_edge) st_d.f.len_short = ba_s;
        if (accept)        st_d.f.busy = 1'b1;
        else if (eng_done) st_d.f.busy = 1'b0;
        if (eng_done) st_d.result = eng_result;
        st_d.f.oe = want_read;
        st_d.dout = want_read ? mux_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_start = st_q.f.start;
    assign len_short  = st_q.f.len_short;
    assign busy       = st_q.f.busy;
    assign data_out   = st_q.dout;
    assign data_oe    = st_q.f.oe;

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> data_out == '0); // R1
    AST_NO_START_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !data_oe); // R2
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R10
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> !conv_start); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R9
    AST_RESULT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> st_q.result == $past(eng_result)); // R10
endmodule

// File: tb/adc_bus_ctrl_tb.sv
module adc_bus_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b0, chip_sel_n = 1'b1, rd_conv = 1'b1;
    logic        byte_addr = 1'b0, word_mode = 1'b1, eng_done = 1'b0;
    logic [11:0] eng_result = '0;
    logic        conv_start, len_short, busy, data_oe;
    logic [11:0] data_out;

    int checks = 0;
    int errors = 0;
    int starts = 0;

    always #10 clk = ~clk;

    adc_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
        .rd_conv(rd_conv), .byte_addr(byte_addr), .word_mode(word_mode),
        .eng_done(eng_done), .eng_result(eng_result), .conv_start(conv_start),
        .len_short(len_short), .busy(busy), .data_out(data_out), .data_oe(data_oe)
    );

    always @(negedge clk) if (conv_start) starts++;

    // word_mode, byte_addr, result, expected data_out
    localparam logic [25:0] VEC [6] = '{
        {1'b1, 1'b0, 12'hA5C, 12'hA5C},
        {1'b0, 1'b0, 12'hA5C, 12'hA50},
        {1'b0, 1'b1, 12'hA5C, 12'hC00},
        {1'b1, 1'b1, 12'h3E7, 12'h3E7},
        {1'b0, 1'b0, 12'h3E7, 12'h3E0},
        {1'b0, 1'b1, 12'h3E7, 12'h700}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_conv(input logic [11:0] res);
        @(negedge clk);
        eng_result = res;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        settle();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1 reset oe", data_oe, 0);
        chk("R1 reset data", data_out, 0);
        chk("R1 reset busy", busy, 0);

        // R1: convert and read requests while deselected
        rd_conv = 1'b0; settle();
        rd_conv = 1'b1; chip_en = 1'b1; settle();
        chk("R1 no start when deselected", starts, 0);
        chk("R1 no drive when deselected", data_oe, 0);

        // vector table: convert, complete, then read
        for (int i = 0; i < 6; i++) begin
            word_mode = VEC[i][25];
            chip_sel_n = 1'b0; rd_conv = 1'b0; byte_addr = 1'b0;
            settle();
            rd_conv = 1'b1; chip_sel_n = 1'b1;
            finish_conv(VEC[i][23:12]);
            byte_addr = VEC[i][24]; chip_sel_n = 1'b0;
            settle();
            chk("R4 R5 R6 read data", data_out, VEC[i][11:0]);
            chk("R2 read enables bus", data_oe, 1);
            chip_sel_n = 1'b1; settle();
        end
        chk("R2 one start per conversion", starts, 6);

        // R12: latency of three edges for data_oe
        @(negedge clk); chip_sel_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R12 not yet driven", data_oe, 0);
        @(negedge clk);
        chk("R12 driven after third edge", data_oe, 1);

        // R7: byte address follows during read (result 3E7, byte mode)
        byte_addr = 1'b0; settle();
        chk("R7 high byte", data_out, 12'h3E0);
        byte_addr = 1'b1; settle();
        chk("R7 follows to low byte", data_out, 12'h700);
        chip_sel_n = 1'b1; settle();

        // R3 and R9: 8-bit start, held condition
        s0 = starts;
        byte_addr = 1'b1; chip_sel_n = 1'b0; rd_conv = 1'b0;
        repeat (10) @(negedge clk);
        chk("R9 single pulse while held", starts - s0, 1);
        chk("R3 short length", len_short, 1);
        chk("R10 busy set", busy, 1);

        // R8: restart edge while busy, new length captured
        rd_conv = 1'b1; settle();
        byte_addr = 1'b0; rd_conv = 1'b0; settle();
        chk("R8 no restart", starts - s0, 1);
        chk("R8 busy kept", busy, 1);
        chk("R8 length recaptured", len_short, 0);

        // R10: start edge in same cycle as done
        rd_conv = 1'b1; settle();
        rd_conv = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        eng_result = 12'h123; eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        settle();
        chk("R10 start accepted with done", starts - s0, 2);
        chk("R10 busy stays set", busy, 1);
        finish_conv(12'h456);
        chk("R10 busy cleared by done", busy, 0);
        rd_conv = 1'b1; word_mode = 1'b1; settle();
        chk("R10 last result read", data_out, 12'h456);

        // R11: stand-alone wiring
        byte_addr = 1'b0; chip_sel_n = 1'b0; chip_en = 1'b1; word_mode = 1'b1;
        s0 = starts;
        rd_conv = 1'b0; settle();
        chk("R11 falling level starts", starts - s0, 1);
        chk("R11 bus floats", data_oe, 0);
        chk("R11 floated data zero", data_out, 0);
        rd_conv = 1'b1;
        finish_conv(12'hBEE);
        chk("R11 high level drives", data_oe, 1);
        chk("R11 result driven", data_out, 12'hBEE);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule